// File: doc/BRIEF.md
# Packed Signed Byte Right Shifter

This execution unit serves one SIMD instruction. It decodes a 32-bit instruction word and takes the low 32 bits of a 64-bit source operand as four independent signed bytes. Every byte moves right arithmetically by the same 3-bit immediate. One variant truncates the discarded bits. The other rounds to nearest, with ties going toward positive infinity.

The 64-bit result keeps each byte in its own lane. The upper 32 bits copy the sign of the most significant lane. The unit also decodes the destination register index and asserts a write strobe.

When the word carries the right major opcode and function code but an illegal sub-field, the unit raises a reserved-instruction flag. When the word is legal but the signed-arithmetic extension is switched off, it raises a disabled-unit flag. In both cases it suppresses the write. A parameter selects either a purely combinational output or one register stage, and the default is one register stage.

Top module: `vshr_byte4`

## Requirements
- R1: The unit recognises the instruction only when bits [31:26] equal 011111 and bits [5:0] equal 010011. Sub-op bits [10:6] equal to 00100 select truncation and 00101 select rounding. Bits [25:24] must be zero. The shift amount is bits [23:21], unsigned 0..7. The destination index bits [15:11] appear on `dst_sel` while `wr_en` is high.
- R2: In the truncating variant, each byte lane i (bits [8i+7:8i]) of `src[31:0]` becomes that signed byte shifted right by the shift amount, with vacated bits filled from the lane's own sign. `src[63:32]` has no effect on the result.
- R3: In the rounding variant with shift amount 0, each of the four result bytes equals its source byte.
- R4: In the rounding variant with shift amount s from 1 to 7, each lane equals floor((v + 2^(s-1)) / 2^s), where v is the signed byte. The result is taken as bits 8..1 of the 9-bit sum of the sign-extended byte shifted by s-1 plus one, and it never saturates.
- R5: `result[63:32]` equals 32 copies of the sign bit of the top lane result.
- R6: `wr_en` is high exactly when the word is legal under R1 and `dsp_en` is high. At most one of `wr_en`, `exc_resv` and `exc_dsp_off` is high.
- R7: A legal word with `dsp_en` low raises `exc_dsp_off` and keeps `wr_en` low.
- R8: A word whose opcode and function match, but whose sub-op is neither legal value or whose bits [25:24] are nonzero, raises `exc_resv` and keeps `wr_en` low. This flag takes precedence over `exc_dsp_off`, so `exc_dsp_off` stays low.
- R9: A word whose opcode or function does not match leaves `wr_en`, `exc_resv` and `exc_dsp_off` all low.
- R10: With REG_OUT=1 (the default), outputs appear one clock after the inputs. While `rst` is high, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word |
| src | input | 64 | Source operand; low 32 bits hold the four bytes |
| dsp_en | input | 1 | Signed-arithmetic extension enable |
| result | output | 64 | Shifted lanes with sign-extended upper half |
| wr_en | output | 1 | Destination write strobe |
| dst_sel | output | 5 | Destination register index |
| exc_resv | output | 1 | Reserved-instruction exception |
| exc_dsp_off | output | 1 | Extension-disabled exception |

## Verification
The checker assumes that the inputs it captures from the previous cycle are the ones the outputs reflect. That holds only when REG_OUT matches the bind parameter and `instr`, `src` and `dsp_en` settle before each rising edge. The bench drives every input on the falling edge, so each value is stable across the following rising edge. It holds reset long enough that the checker's delayed copies start from the same cleared state as the outputs. The stimulus covers every byte value in every lane for all eight shift amounts and both variants. The upper half of the source carries nonzero patterns, so any leak from it into the result would show.

// File: rtl/vshr_pkg.sv
package vshr_pkg;
    localparam int XLEN   = 64;
    localparam int ILEN   = 32;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int SA_W   = $clog2(LANE_W);
    localparam int REG_W  = 5;
    localparam int VEC_W  = LANES * LANE_W;

    localparam logic [5:0] OPC_MAJOR = 6'b011111;
    localparam logic [5:0] FN_CODE   = 6'b010011;
    localparam logic [4:0] SUB_TRUNC = 5'b00100;
    localparam logic [4:0] SUB_ROUND = 5'b00101;

    typedef struct packed {
        logic              hit;
        logic              legal;
        logic              rnd;
        logic [SA_W-1:0]   amt;
        logic [REG_W-1:0]  dst;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0]   value;
        logic              wr;
        logic [REG_W-1:0]  dst;
        logic              resv;
        logic              doff;
    } out_t;

    function automatic logic sub_is_legal(input logic [4:0] s);
        return (s == SUB_TRUNC) || (s == SUB_ROUND);
    endfunction
endpackage

// File: rtl/vshr_decode.sv
module vshr_decode
    import vshr_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output dec_t            dec
);
    logic [4:0] sub;
    logic       unused_rt;

    assign sub       = instr[10:6];
    assign unused_rt = ^instr[20:16];

    always_comb begin
        dec.hit   = (instr[31:26] == OPC_MAJOR) && (instr[5:0] == FN_CODE);
        dec.legal = dec.hit && sub_is_legal(sub) && (instr[25:24] == 2'b00);
        dec.rnd   = (sub == SUB_ROUND);
        dec.amt   = instr[23:21];
        dec.dst   = instr[15:11];
    end
endmodule

// File: rtl/vshr_lane.sv
module vshr_lane #(
    parameter int W  = 8,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          rnd,
    output logic [W-1:0]  dout,
    output logic          sgn
);
    logic signed [W:0] ext;
    logic signed [W:0] sum;

    assign ext = {din[W-1], din};

    always_comb begin
        sum = '0;
        if (!rnd) begin
            dout = W'($signed(din) >>> amt);
            sgn  = dout[W-1];
        end else if (amt == '0) begin
            dout = din;
            sgn  = din[W-1];
        end else begin
            sum  = (ext >>> (amt - SW'(1))) + (W+1)'(1);
            dout = sum[W:1];
            sgn  = sum[W];
        end
    end
endmodule

// File: rtl/vshr_stage.sv
module vshr_stage
    import vshr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  out_t d,
    output out_t q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_comb
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/vshr_byte4.sv
module vshr_byte4
    import vshr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ILEN-1:0]   instr,
    input  logic [XLEN-1:0]   src,
    input  logic              dsp_en,
    output logic [XLEN-1:0]   result,
    output logic              wr_en,
    output logic [REG_W-1:0]  dst_sel,
    output logic              exc_resv,
    output logic              exc_dsp_off
);
    localparam int HI_W = XLEN - VEC_W;

    dec_t             dec;
    logic [VEC_W-1:0] lanes;
    logic [LANES-1:0] sgns;
    out_t             nxt;
    out_t             cur;
    logic             unused_hi;

    assign unused_hi = ^src[XLEN-1:VEC_W];

    vshr_decode u_dec (.instr(instr), .dec(dec));

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            vshr_lane #(.W(LANE_W), .SW(SA_W)) u_lane (
                .din (src[i*LANE_W +: LANE_W]),
                .amt (dec.amt),
                .rnd (dec.rnd),
                .dout(lanes[i*LANE_W +: LANE_W]),
                .sgn (sgns[i])
            );
        end
    endgenerate

    always_comb begin
        nxt.value = {{HI_W{sgns[LANES-1]}}, lanes};
        nxt.wr    = dec.legal && dsp_en;
        nxt.dst   = dec.dst;
        nxt.resv  = dec.hit && !dec.legal;
        nxt.doff  = dec.legal && !dsp_en;
    end

    vshr_stage #(.REG_OUT(REG_OUT)) u_stage (.clk(clk), .rst(rst), .d(nxt), .q(cur));

    assign result      = cur.value;
    assign wr_en       = cur.wr;
    assign dst_sel     = cur.dst;
    assign exc_resv    = cur.resv;
    assign exc_dsp_off = cur.doff;
endmodule

// File: rtl/vshr_byte4_chk.sv
module vshr_byte4_chk
    import vshr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [ILEN-1:0]   instr,
    input logic [XLEN-1:0]   src,
    input logic              dsp_en,
    input logic [XLEN-1:0]   result,
    input logic              wr_en,
    input logic [REG_W-1:0]  dst_sel,
    input logic              exc_resv,
    input logic              exc_dsp_off
);
    logic [ILEN-1:0]  iq;
    logic [VEC_W-1:0] sq;
    logic             eq;
    logic             unused_src;

    assign unused_src = ^src[XLEN-1:VEC_W];

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    iq <= '0; sq <= '0; eq <= 1'b0;
                end else begin
                    iq <= instr; sq <= src[VEC_W-1:0]; eq <= dsp_en;
                end
            end
        end else begin : g_now
            assign iq = instr;
            assign sq = src[VEC_W-1:0];
            assign eq = dsp_en;
        end
    endgenerate

    logic m_hit, m_ok;
    assign m_hit = (iq[31:26] == 6'b011111) && (iq[5:0] == 6'b010011);
    assign m_ok  = m_hit && (iq[25:24] == 2'b00) &&
                   ((iq[10:6] == 5'b00100) || (iq[10:6] == 5'b00101));

    p_one_flag_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, exc_resv, exc_dsp_off}));
    p_write_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en == (m_ok && eq));
    p_dsp_off_r7: assert property (@(posedge clk) disable iff (rst)
        (m_ok && !eq) |-> (exc_dsp_off && !wr_en));
    p_resv_r8: assert property (@(posedge clk) disable iff (rst)
        (m_hit && !m_ok) |-> (exc_resv && !wr_en && !exc_dsp_off));
    p_nomatch_r9: assert property (@(posedge clk) disable iff (rst)
        !m_hit |-> (!wr_en && !exc_resv && !exc_dsp_off));
    p_sext_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (result[XLEN-1:VEC_W] == {(XLEN-VEC_W){result[VEC_W-1]}}));
    p_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && iq[10:6] == 5'b00101 && iq[23:21] == 3'd0) |-> (result[VEC_W-1:0] == sq));
    p_dst_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (dst_sel == iq[15:11]));
endmodule

bind vshr_byte4 vshr_byte4_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_vshr_byte4.sv
`timescale 1ns/1ps
module sim_vshr_byte4;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic [63:0] src = '0;
    logic        dsp_en = 1'b0;
    logic [63:0] result;
    logic        wr_en;
    logic [4:0]  dst_sel;
    logic        exc_resv;
    logic        exc_dsp_off;

    always #10 clk = ~clk;

    vshr_byte4 u0 (.clk(clk), .rst(rst), .instr(instr), .src(src), .dsp_en(dsp_en),
                   .result(result), .wr_en(wr_en), .dst_sel(dst_sel),
                   .exc_resv(exc_resv), .exc_dsp_off(exc_dsp_off));

    typedef struct packed {
        logic [63:0] value;
        logic        chk_val;
        logic        wr;
        logic        resv;
        logic        doff;
        logic [4:0]  dst;
        logic [3:0]  tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd1: return "R1"; 4'd2: return "R2"; 4'd3: return "R3";
            4'd4: return "R4"; 4'd7: return "R7"; 4'd8: return "R8";
            4'd9: return "R9"; default: return "R10";
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [1:0] z,
                                       input logic [2:0] sa, input logic [4:0] rd,
                                       input logic [4:0] sub, input logic [5:0] fn);
        return {op, z, sa, 5'd9, rd, sub, fn};
    endfunction

    function automatic logic [7:0] ref_lane(input logic [7:0] b, input int sa, input bit rnd);
        int v;
        v = int'($signed(b));
        if (!rnd)         v = v >>> sa;
        else if (sa != 0) v = (v + (1 << (sa - 1))) >>> sa;
        return v[7:0];
    endfunction

    task automatic cmp(input string tg, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] i, input logic [63:0] s, input logic en, input exp_t e);
        exp_t h;
        @(negedge clk);
        if (q.size() > 0) begin
            h = q.pop_front();
            if (h.chk_val) begin
                cmp(tname(h.tag), {32'd0, result[31:0]}, {32'd0, h.value[31:0]});
                cmp("R5", {32'd0, result[63:32]}, {32'd0, h.value[63:32]});
                cmp("R1", {59'd0, dst_sel}, {59'd0, h.dst});
            end
            cmp(h.tag == 4'd7 ? "R7" : h.tag == 4'd8 ? "R8" : h.tag == 4'd9 ? "R9" : "R6",
                {61'd0, wr_en, exc_resv, exc_dsp_off}, {61'd0, h.wr, h.resv, h.doff});
        end
        instr = i; src = s; dsp_en = en;
        q.push_back(e);
    endtask

    function automatic exp_t flags_only(input bit w, input bit r, input bit d, input logic [3:0] t);
        exp_t e;
        e = '0; e.wr = w; e.resv = r; e.doff = d; e.tag = t;
        return e;
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t e;
        logic [7:0] b [4];
        logic [31:0] lo;
        repeat (3) @(negedge clk);
        // R10: outputs are zero while reset is held
        cmp("R10", result, 64'd0);
        cmp("R10", {61'd0, wr_en, exc_resv, exc_dsp_off}, 64'd0);
        cmp("R10", {59'd0, dst_sel}, 64'd0);
        instr = mk(6'b011111, 2'b00, 3'd2, 5'd3, 5'b00100, 6'b010011);
        src = 64'h0000_0000_8040_2010;
        dsp_en = 1'b1;
        @(negedge clk);
        cmp("R10", result, 64'd0);
        rst = 1'b0;

        // R2 R3 R4 R5: every byte value in every lane, all shifts, both variants
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int sa = 0; sa < 8; sa++) begin
                for (int v = 0; v < 256; v++) begin
                    b[0] = 8'(v);
                    b[1] = 8'(v) ^ 8'h5A;
                    b[2] = 8'(v + 85);
                    b[3] = ~8'(v);
                    lo = {b[3], b[2], b[1], b[0]};
                    e = '0;
                    for (int k = 0; k < 4; k++) e.value[k*8 +: 8] = ref_lane(b[k], sa, rnd[0]);
                    e.value[63:32] = {32{e.value[31]}};
                    e.chk_val = 1'b1; e.wr = 1'b1; e.dst = 5'(v);
                    e.tag = (rnd == 0) ? 4'd2 : (sa == 0) ? 4'd3 : 4'd4;
                    step(mk(6'b011111, 2'b00, 3'(sa), 5'(v), rnd ? 5'b00101 : 5'b00100, 6'b010011),
                         {~lo ^ 32'hC3A5_0F96, lo}, 1'b1, e);
                end
            end
        end

        // R4: extreme rounding points, no saturation
        e = '0; e.chk_val = 1; e.wr = 1; e.dst = 5'd31; e.tag = 4'd4;
        e.value = {32'h0, 8'h40, 8'hC0, 8'h00, 8'h01};
        step(mk(6'b011111, 2'b00, 3'd1, 5'd31, 5'b00101, 6'b010011), 64'hFFFF_FFFF_7F80_FF01, 1'b1, e);

        // R7: disabled extension, both variants
        step(mk(6'b011111, 2'b00, 3'd3, 5'd4, 5'b00100, 6'b010011), 64'h1234, 1'b0, flags_only(0, 0, 1, 4'd7));
        step(mk(6'b011111, 2'b00, 3'd3, 5'd4, 5'b00101, 6'b010011), 64'h1234, 1'b0, flags_only(0, 0, 1, 4'd7));
        // R8: bad sub-op, nonzero zero field, and precedence over disabled
        step(mk(6'b011111, 2'b00, 3'd1, 5'd4, 5'b00110, 6'b010011), 64'h1, 1'b1, flags_only(0, 1, 0, 4'd8));
        step(mk(6'b011111, 2'b10, 3'd1, 5'd4, 5'b00100, 6'b010011), 64'h1, 1'b1, flags_only(0, 1, 0, 4'd8));
        step(mk(6'b011111, 2'b01, 3'd1, 5'd4, 5'b00101, 6'b010011), 64'h1, 1'b0, flags_only(0, 1, 0, 4'd8));
        step(mk(6'b011111, 2'b00, 3'd1, 5'd4, 5'b00000, 6'b010011), 64'h1, 1'b0, flags_only(0, 1, 0, 4'd8));
        // R9: other opcode or function
        step(mk(6'b011110, 2'b00, 3'd1, 5'd4, 5'b00100, 6'b010011), 64'h1, 1'b1, flags_only(0, 0, 0, 4'd9));
        step(mk(6'b011111, 2'b00, 3'd1, 5'd4, 5'b00100, 6'b010010), 64'h1, 1'b1, flags_only(0, 0, 0, 4'd9));
        step(32'h0, 64'h1, 1'b0, flags_only(0, 0, 0, 4'd9));
        // flush the last expectation
        step(32'h0, 64'h0, 1'b0, flags_only(0, 0, 0, 4'd9));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule